// File: doc/BRIEF.md
# Latched BCD Seven-Segment LCD Decoder

This block turns a four-bit decimal digit into drive levels for the seven segments of a liquid-crystal digit. A register captures the incoming digit on each clock edge where the load enable is high and keeps it while the enable is low. The decoder runs from that stored digit, so a shared data bus can feed several digits, each loading at its own moment.

A blank input switches every segment off. Digit values from 10 to 15 are not decimal and also blank the digit. A phase input inverts all seven outputs. The user drives the phase input with the same square wave that drives the display backplane, so no segment ever sees a DC voltage. Blanking and phase act combinationally on the stored digit. Only the digit itself waits for a clock edge.

Top module: `lcdDigitDecoder`

## Requirements
- R1: On every rising clock edge where `loadEn` is high, the register captures `bcdIn`. On every edge where `loadEn` is low, it keeps its value whatever `bcdIn` does.
- R2: When `blank` is high, the segments take the blank level (all 0 with `phase` low), whatever the stored digit and `loadEn`.
- R3: Stored values 10 to 15 give the blank level.
- R4: With `blank` low and `phase` low, `seg` (bit 6 = a down to bit 0 = g) shows these patterns for digits 0 to 4: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011.
- R5: With `blank` low and `phase` low, `seg` shows these patterns for digits 5 to 9: 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011. Digit 6 has segment a lit and digit 9 has segment d lit.
- R6: When `phase` is high, `seg` is the bitwise inverse of its value with `phase` low. This includes the blanked cases, which then give 1111111. The change appears in the same cycle, without waiting for a clock edge.
- R7: Reset (`rst_n` low) clears the stored digit to 0. After reset, with `blank` and `phase` low, `seg` reads 1111110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Load enable for the digit register, active high |
| bcdIn | input | 4 | Digit input, bit 0 least significant |
| blank | input | 1 | Forces all segments off, active high |
| phase | input | 1 | Inverts all segments, active high |
| seg | output | 7 | Segment levels, bit 6 = a through bit 0 = g |

## Verification
The bench loads all sixteen codes and checks each one under all four combinations of blank and phase. An error in the pattern table, or a non-decimal code that leaks a stray segment, shows up there directly. Feeding changing data while the load enable is low catches a register that loads too eagerly. Checking blanked digits with phase high catches a design that applies inversion before blanking, which would leave the blanked outputs low instead of all high. The tails on 6 and 9 are checked by name, because the tailless shapes are a common error.

// File: rtl/lcdDigitPkg.sv
package lcdDigitPkg;
  localparam int CODE_W = 4;
  localparam int SEG_W  = 7;
  localparam int LAST_DIGIT = 9;

  typedef struct packed {
    logic load;
    logic blankAll;
    logic invert;
  } digitCtrl_t;
endpackage

// File: rtl/lcdDigitCtrl.sv
module lcdDigitCtrl
  import lcdDigitPkg::*;
(
  input  logic       loadEn,
  input  logic       blank,
  input  logic       phase,
  output digitCtrl_t ctrl
);
  always_comb begin
    ctrl.load     = loadEn;
    ctrl.blankAll = blank;
    ctrl.invert   = phase;
  end
endmodule

// File: rtl/lcdDigitPath.sv
module lcdDigitPath
  import lcdDigitPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  digitCtrl_t        ctrl,
  input  logic [CODE_W-1:0] bcdIn,
  output logic [SEG_W-1:0]  seg
);
  logic [CODE_W-1:0] heldCode;
  logic [SEG_W-1:0]  glyph;
  logic [SEG_W-1:0]  gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         heldCode <= '0;
    else if (ctrl.load) heldCode <= bcdIn;
  end

  always_comb begin
    unique case (heldCode)
      4'd0: glyph = 7'b1111110;
      4'd1: glyph = 7'b0110000;
      4'd2: glyph = 7'b1101101;
      4'd3: glyph = 7'b1111001;
      4'd4: glyph = 7'b0110011;
      4'd5: glyph = 7'b1011011;
      4'd6: glyph = 7'b1011111;
      4'd7: glyph = 7'b1110000;
      4'd8: glyph = 7'b1111111;
      4'd9: glyph = 7'b1111011;
      default: glyph = '0;
    endcase
  end

  always_comb begin
    gated = (ctrl.blankAll || (heldCode > CODE_W'(LAST_DIGIT))) ? '0 : glyph;
    seg   = gated ^ {SEG_W{ctrl.invert}};
  end
endmodule

// File: rtl/lcdDigitDecoder.sv
module lcdDigitDecoder
  import lcdDigitPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loadEn,
  input  logic [3:0] bcdIn,
  input  logic       blank,
  input  logic       phase,
  output logic [6:0] seg
);
  digitCtrl_t ctrl;

  lcdDigitCtrl u_ctrl (.loadEn(loadEn), .blank(blank), .phase(phase), .ctrl(ctrl));
  lcdDigitPath u_path (.clk(clk), .rst_n(rst_n), .ctrl(ctrl), .bcdIn(bcdIn), .seg(seg));
endmodule

// File: rtl/lcdDigitChecker.sv
module lcdDigitChecker (
  input logic       clk,
  input logic       rst_n,
  input logic       loadEn,
  input logic [3:0] bcdIn,
  input logic       blank,
  input logic       phase,
  input logic [6:0] seg
);
  // R2: blanking gives all off (low phase) or all on (high phase)
  p_blank_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (seg == {7{phase}}));

  // R6: phase toggle alone flips every segment
  p_phase_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(loadEn) && $stable(blank) && (phase != $past(phase)))
      |-> (seg == ~$past(seg)));

  // R1: output stable when nothing can change it
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(loadEn) && $stable(blank) && $stable(phase)) |-> $stable(seg));

  // R3: a loaded non-decimal code blanks
  p_illegal_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEn && bcdIn > 4'd9) |=> (seg == {7{phase}}));

  // R4: loaded zero shows its pattern when shown plainly
  p_zero_glyph_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEn && bcdIn == 4'd0) |=> ((blank || phase) || seg == 7'b1111110));

  // R5: loaded eight lights everything when shown plainly
  p_eight_glyph_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEn && bcdIn == 4'd8) |=> ((blank || phase) || seg == 7'b1111111));
endmodule

bind lcdDigitDecoder lcdDigitChecker u_chk (
  .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .bcdIn(bcdIn),
  .blank(blank), .phase(phase), .seg(seg));

// File: tb/lcdDigitDecoder_tb.sv
module lcdDigitDecoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadEn = 1'b0;
  logic [3:0] bcdIn = 4'd0;
  logic blank = 1'b0;
  logic phase = 1'b0;
  logic [6:0] seg;

  int checks = 0;
  int failures = 0;
  int modelCode = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcdDigitDecoder u_dut (.clk(clk), .rst_n(rst_n), .loadEn(loadEn), .bcdIn(bcdIn),
                         .blank(blank), .phase(phase), .seg(seg));

  function automatic logic [6:0] refSeg(int code, bit b, bit p);
    logic [6:0] v;
    case (code)
      0: v = 7'b1111110; 1: v = 7'b0110000; 2: v = 7'b1101101;
      3: v = 7'b1111001; 4: v = 7'b0110011; 5: v = 7'b1011011;
      6: v = 7'b1011111; 7: v = 7'b1110000; 8: v = 7'b1111111;
      9: v = 7'b1111011; default: v = 7'b0000000;
    endcase
    if (b) v = 7'b0000000;
    return p ? ~v : v;
  endfunction

  task automatic check(string req);
    logic [6:0] exp;
    exp = refSeg(modelCode, blank, phase);
    checks++;
    if (seg !== exp) begin
      failures++;
      $display("FAIL %s code=%0d blank=%0b phase=%0b actual=%b expected=%b",
               req, modelCode, blank, phase, seg, exp);
    end
  endtask

  // reference model: update the stored code at each edge, then compare every clock
  always @(posedge clk) begin
    if (rst_n && loadEn) modelCode <= int'(bcdIn);
  end

  always @(negedge clk) begin
    if (rst_n && !done) check("EVERY");
  end

  task automatic loadCode(int c);
    @(negedge clk);
    bcdIn = 4'(c); loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL WATCHDOG actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R7");
    // all codes under all blank/phase combos
    for (int c = 0; c < 16; c++) begin
      loadCode(c);
      for (int k = 0; k < 4; k++) begin
        blank = k[0]; phase = k[1];
        #1;
        if (c > 9)       check("R3");
        else if (k[0])   check("R2");
        else if (k[1])   check("R6");
        else if (c < 5)  check("R4");
        else             check("R5");
      end
      blank = 1'b0; phase = 1'b0;
    end
    // tails on 6 and 9
    loadCode(6); #1 check("R5_tail6");
    loadCode(9); #1 check("R5_tail9");
    // hold while loadEn low, inputs change
    loadCode(3);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bcdIn = 4'(i * 2 + 1);
      @(negedge clk); #1 check("R1");
    end
    // blank ignores loads of data while blank high; stored code still updates
    blank = 1'b1;
    loadCode(7); #1 check("R2");
    blank = 1'b0; #1 check("R1");
    // R3 with phase
    phase = 1'b1; loadCode(12); #1 check("R3"); phase = 1'b0;
    // reset clears
    loadCode(5);
    rst_n = 1'b0; #1;
    modelCode = 0;
    @(negedge clk); rst_n = 1'b1; #1 check("R7");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule